// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This combinational block sits right after the instruction memory read port in a small 32-bit processor. The instruction set has encodings of one to six bytes. The block takes the current program counter and the six bytes stored from that address upward. From the leading byte alone it works out whether the instruction carries a register-specifier byte and a four-byte constant. It then extracts every field and produces the address of the following instruction.

Fields that an encoding does not carry are forced to fixed values, so that later stages never have to qualify them. A register field that is absent reads as the "no register" code 8. A constant that is absent reads as zero. Leading bytes whose upper nibble matches no defined operation are flagged as invalid. They are still given a length of one byte, so the next-address output stays well defined.

Top module: `fetch_aligner`

## Requirements
- R1: The operation code output equals bits [7:4] of the leading byte (byte 0, held in bits [7:0] of the byte input), and the function output equals bits [3:0] of that byte, for every value of the byte.
- R2: The valid flag is 1 exactly when the operation code is one of 0x0 (halt), 0x1 (nop), 0x2 (register copy), 0x3 (load immediate), 0x4 (store), 0x5 (load), 0x6 (ALU), 0x7 (branch), 0x8 (call), 0x9 (return), 0xA (push) or 0xB (pop), and is 0 for 0xC to 0xF.
- R3: For codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, byte 1 is a register byte: the first register output is its bits [7:4] and the second register output is its bits [3:0].
- R4: For codes 0x0, 0x1, 0x7, 0x8 and 0x9, both register outputs are 8.
- R5: For codes 0x3, 0x4, 0x5, 0x7 and 0x8, the constant output is four bytes assembled little-endian (the lowest address is the least significant byte). The first of those bytes is byte 2 when a register byte is present and byte 1 when it is not.
- R6: For codes 0x0, 0x1, 0x2, 0x6, 0x9, 0xA and 0xB, the constant output is zero, whatever the other bytes hold.
- R7: The next-address output is the PC plus the length: 1, plus 1 for a register byte, plus 4 for a constant. The result is taken modulo 2^32.
- R8: For the undefined codes 0xC to 0xF, the next address is PC+1, both register outputs are 8 and the constant output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the leading byte |
| ibytes_i | input | 48 | Six bytes from the PC upward; byte k in bits [8k+7:8k] |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier, 8 when absent |
| rb_o | output | 4 | Second register specifier, 8 when absent |
| valc_o | output | 32 | Constant word, zero when absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| valid_o | output | 1 | Operation code is defined |

## Verification
The bench targets the constant offset, which shifts by one byte when a register byte is present. A design that ignored the shift would return the constant rotated by a byte, for example 0x00abcd82 instead of 0x0000abcd for the load-immediate case. The bench places non-zero data in the bytes that absent fields would occupy, for return, branch and the undefined codes. A design that did not force defaults would leak those bytes into the register or constant outputs. It also places the PC just below the top of the address space, so that a next-address adder that is too narrow or saturates would give a wrong wrapped address. Finally, all sixteen codes are swept, which exposes any code placed in the wrong length class or any undefined code marked valid.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam logic [NIB_W-1:0] REG_NONE = 4'h8;

  typedef enum logic [NIB_W-1:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RMOV  = 4'h2,
    OP_IMOV  = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } op_e;
endpackage

// File: rtl/fa_classify.sv
module fa_classify
  import fa_pkg::*;
(
  input  logic [NIB_W-1:0] code_i,
  output logic             has_reg_o,
  output logic             has_const_o,
  output logic             known_o
);
  always_comb begin
    has_reg_o   = 1'b0;
    has_const_o = 1'b0;
    known_o     = 1'b0;
    case (op_e'(code_i))
      OP_HALT, OP_NOP, OP_RET: begin
        known_o = 1'b1;
      end
      OP_RMOV, OP_ALU, OP_PUSH, OP_POP: begin
        known_o   = 1'b1;
        has_reg_o = 1'b1;
      end
      OP_IMOV, OP_STORE, OP_LOAD: begin
        known_o     = 1'b1;
        has_reg_o   = 1'b1;
        has_const_o = 1'b1;
      end
      OP_JUMP, OP_CALL: begin
        known_o     = 1'b1;
        has_const_o = 1'b1;
      end
      default: begin
        known_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fa_extract.sv
module fa_extract
  import fa_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned TAIL_BYTES = WORD_BYTES + 1,
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES
) (
  input  logic [BYTE_W*TAIL_BYTES-1:0] tail_i,
  input  logic                         has_reg_i,
  input  logic                         has_const_i,
  output logic [NIB_W-1:0]             ra_o,
  output logic [NIB_W-1:0]             rb_o,
  output logic [WORD_W-1:0]            valc_o
);
  assign ra_o = has_reg_i ? tail_i[BYTE_W-1 -: NIB_W] : REG_NONE;
  assign rb_o = has_reg_i ? tail_i[NIB_W-1:0]         : REG_NONE;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
    logic [BYTE_W-1:0] pick;
    assign pick = has_reg_i ? tail_i[BYTE_W*(k+1) +: BYTE_W]
                            : tail_i[BYTE_W*k     +: BYTE_W];
    assign valc_o[BYTE_W*k +: BYTE_W] = has_const_i ? pick : '0;
  end
endmodule

// File: rtl/fa_length.sv
module fa_length #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned STEP_W    = $clog2(WORD_BYTES + 3)
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              has_reg_i,
  input  logic              has_const_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [STEP_W-1:0] step;

  always_comb begin
    step = STEP_W'(1) + STEP_W'(has_reg_i)
         + (has_const_i ? STEP_W'(WORD_BYTES) : STEP_W'(0));
  end

  assign next_o = pc_i + ADDR_W'(step);
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned FETCH_BYTES = WORD_BYTES + 2,
  localparam int unsigned WORD_W      = BYTE_W * WORD_BYTES
) (
  input  logic [ADDR_W-1:0]             pc_i,
  input  logic [BYTE_W*FETCH_BYTES-1:0] ibytes_i,
  output logic [NIB_W-1:0]              icode_o,
  output logic [NIB_W-1:0]              ifun_o,
  output logic [NIB_W-1:0]              ra_o,
  output logic [NIB_W-1:0]              rb_o,
  output logic [WORD_W-1:0]             valc_o,
  output logic [ADDR_W-1:0]             valp_o,
  output logic                          valid_o
);
  logic has_reg;
  logic has_const;

  assign icode_o = ibytes_i[BYTE_W-1 -: NIB_W];
  assign ifun_o  = ibytes_i[NIB_W-1:0];

  fa_classify u_class (
    .code_i      (icode_o),
    .has_reg_o   (has_reg),
    .has_const_o (has_const),
    .known_o     (valid_o)
  );

  fa_extract #(.WORD_BYTES(WORD_BYTES)) u_extract (
    .tail_i      (ibytes_i[BYTE_W*FETCH_BYTES-1:BYTE_W]),
    .has_reg_i   (has_reg),
    .has_const_i (has_const),
    .ra_o        (ra_o),
    .rb_o        (rb_o),
    .valc_o      (valc_o)
  );

  fa_length #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_len (
    .pc_i        (pc_i),
    .has_reg_i   (has_reg),
    .has_const_i (has_const),
    .next_o      (valp_o)
  );
endmodule

// File: rtl/fa_checker.sv
module fa_checker
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned FETCH_BYTES = WORD_BYTES + 2,
  localparam int unsigned WORD_W      = BYTE_W * WORD_BYTES
) (
  input logic [ADDR_W-1:0]             pc_i,
  input logic [BYTE_W*FETCH_BYTES-1:0] ibytes_i,
  input logic [NIB_W-1:0]              icode_o,
  input logic [NIB_W-1:0]              ifun_o,
  input logic [NIB_W-1:0]              ra_o,
  input logic [NIB_W-1:0]              rb_o,
  input logic [WORD_W-1:0]             valc_o,
  input logic [ADDR_W-1:0]             valp_o,
  input logic                          valid_o
);
  logic [ADDR_W-1:0] len;

  always_comb begin
    len = valp_o - pc_i;
    // R1
    p_split_r1: assert ({icode_o, ifun_o} == ibytes_i[BYTE_W-1:0])
      else $error("code split mismatch");
    // R2
    p_valid_range_r2: assert (valid_o == (icode_o <= 4'hB))
      else $error("valid flag wrong for code %h", icode_o);
    // R7
    p_len_set_r7: assert (len == 1 || len == 2 || len == WORD_BYTES + 1 || len == WORD_BYTES + 2)
      else $error("illegal length %0d", len);
    // R4
    if (len == 1 || len == WORD_BYTES + 1)
      p_noreg_r4: assert (ra_o == REG_NONE && rb_o == REG_NONE)
        else $error("absent register not reported as none");
    // R3
    if (len == 2 || len == WORD_BYTES + 2)
      p_regbyte_r3: assert ({ra_o, rb_o} == ibytes_i[2*BYTE_W-1:BYTE_W])
        else $error("register byte not passed through");
    // R6
    if (len <= 2)
      p_noconst_r6: assert (valc_o == '0)
        else $error("constant not zero when absent");
    // R5
    if (len == WORD_BYTES + 1)
      p_const_short_r5: assert (valc_o == ibytes_i[BYTE_W +: WORD_W])
        else $error("constant at offset 1 wrong");
    if (len == WORD_BYTES + 2)
      p_const_long_r5: assert (valc_o == ibytes_i[2*BYTE_W +: WORD_W])
        else $error("constant at offset 2 wrong");
    // R8
    if (!valid_o)
      p_invalid_len_r8: assert (len == 1)
        else $error("undefined code not given length 1");
  end
endmodule

bind fetch_aligner fa_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .pc_i     (pc_i),
  .ibytes_i (ibytes_i),
  .icode_o  (icode_o),
  .ifun_o   (ifun_o),
  .ra_o     (ra_o),
  .rb_o     (rb_o),
  .valc_o   (valc_o),
  .valp_o   (valp_o),
  .valid_o  (valid_o)
);

// File: tb/fetch_aligner_bench.sv
module fetch_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_i;
  logic [47:0] ibytes_i;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
  logic [31:0] valc_o, valp_o;
  logic        valid_o;

  fetch_aligner u_fetch_aligner (
    .pc_i(pc_i), .ibytes_i(ibytes_i), .icode_o(icode_o), .ifun_o(ifun_o),
    .ra_o(ra_o), .rb_o(rb_o), .valc_o(valc_o), .valp_o(valp_o), .valid_o(valid_o)
  );

  typedef struct {
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp;
    logic        valid;
    string       reg_tag, const_tag, len_tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] pc, input logic [47:0] b);
    exp_t e;
    bit   r, c;
    logic [3:0] code;
    code = b[7:4];
    r = (code inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
    c = (code inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
    e.icode = code;
    e.ifun  = b[3:0];
    e.valid = (code < 4'hC);
    e.ra    = r ? b[15:12] : 4'h8;
    e.rb    = r ? b[11:8]  : 4'h8;
    e.valc  = !c ? 32'h0 : (r ? b[47:16] : b[39:8]);
    e.valp  = pc + 32'(1 + (r ? 1 : 0) + (c ? 4 : 0));
    e.reg_tag   = !e.valid ? "R8" : (r ? "R3" : "R4");
    e.const_tag = !e.valid ? "R8" : (c ? "R5" : "R6");
    e.len_tag   = !e.valid ? "R8" : "R7";
    return e;
  endfunction

  task automatic drive(input logic [31:0] pc, input logic [47:0] b);
    @(posedge clk);
    pc_i     = pc;
    ibytes_i = b;
    q.push_back(model(pc, b));
  endtask

  // monitor: compares half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(icode_o == e.icode && ifun_o == e.ifun, "R1", "code/fun",
              {24'h0, icode_o, ifun_o}, {24'h0, e.icode, e.ifun});
        check(valid_o == e.valid, "R2", "valid", {31'h0, valid_o}, {31'h0, e.valid});
        check(ra_o == e.ra && rb_o == e.rb, e.reg_tag, "ra/rb",
              {24'h0, ra_o, rb_o}, {24'h0, e.ra, e.rb});
        check(valc_o == e.valc, e.const_tag, "valc", valc_o, e.valc);
        check(valp_o == e.valp, e.len_tag, "valp", valp_o, e.valp);
      end
    end
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    pc_i     = '0;
    ibytes_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state pattern: all zero bytes is halt, R2/R4/R6/R7
    drive(32'h0, 48'h0);
    // halt with non-zero function nibble, R1
    drive(32'h10, 48'hffff_ffff_ff05);
    drive(32'h100, 48'h0000_0000_0010);          // nop
    drive(32'h104, 48'h0000_0000_0660);          // ALU add ra=0 rb=6, R3
    drive(32'h106, 48'h1111_1111_2361);          // ALU sub, junk beyond, R6
    drive(32'h108, 48'h0000_0000_4320);          // register copy
    drive(32'h200, 48'h0000_abcd_8230);          // load immediate, R5 offset 2
    drive(32'h206, 48'h0000_041c_6440);          // store
    drive(32'h20c, 48'hffff_fff4_1550);          // load, negative displacement
    drive(32'h300, 48'hee44_3322_1173);          // branch, R5 offset 1
    drive(32'h305, 48'h5500_0000_2880);          // call
    drive(32'h30a, 48'haaaa_aaaa_aa90);          // return with junk, R4/R6
    drive(32'h30b, 48'h9999_9999_28a0);          // push
    drive(32'h30d, 48'h9999_9999_38b0);          // pop
    // undefined codes with junk bytes, R8
    drive(32'h400, 48'h7766_5544_33c7);
    drive(32'h401, 48'hffff_ffff_fffe);
    // address wrap, R7
    drive(32'hffff_fffc, 48'h1234_5678_0130);
    drive(32'hffff_ffff, 48'h0000_0000_0010);
    // sweep all codes with varied bytes
    for (int c = 0; c < 16; c++) begin
      logic [47:0] b;
      b = {8'(c * 17 + 3), 8'(c * 29 + 5), 8'(c * 7 + 1), 8'(c * 13 + 9),
           8'(c * 11 + 4), 4'(c), 4'(15 - c)};
      drive(32'h1000 + 32'(c * 8), b);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule